// File: doc/BRIEF.md
# Masked Vector AND-NOT Unit

This block is the execution stage for a vector logic operation that complements one source vector and ANDs it with another. It handles vectors of 64, 128, 256 or 512 bits, split into 32-bit or 64-bit elements. The second source can be replaced by one scalar copied into every element. A per-element write mask decides which elements receive the new value. Elements that are not selected either keep the old destination contents (merge) or are cleared (zeroing).

A form select chooses between two cases. In the two-operand form the old destination value is itself the complemented operand, and the unmasked legacy behaviour applies. In the three-operand form the separate first-source port is complemented. The surrounding pipeline presents all operands together with a valid strobe, and one clock edge later the unit returns a registered 512-bit result with its own valid strobe.

Top module: `vandn_unit`

## Requirements
- R1: Within the active length, each result bit of a written element is 1 only when the complemented operand's bit is 0 and the second operand's bit is 1.
- R2: When `dest_src`=1 (two-operand form), `old_dst` is the complemented operand and `src_a` is ignored. `mask_en`, `bcast_en` and `zero_en` are also ignored, so every active element is written. Bits above the active length equal `old_dst`.
- R3: `len_sel` sets the active length: 0 gives 64 bits, 1 gives 128, 2 gives 256 and 3 gives 512.
- R4: When `dest_src`=0, result bits at or above the active length are 0.
- R5: With `elem64`=0, element i is bits [32i+31:32i] and is governed by `mask[i]`. With `elem64`=1, element i is bits [64i+63:64i] and is governed by `mask[i]`.
- R6: When `bcast_en`=1 and `dest_src`=0, the second operand is `src_b[31:0]` copied into every 32-bit element, or `src_b[63:0]` copied into every 64-bit element, following `elem64`.
- R7: When `mask_en`=1 and `zero_en`=0, an active element whose mask bit is 0 keeps its `old_dst` value.
- R8: When `mask_en`=1 and `zero_en`=1, an active element whose mask bit is 0 becomes 0.
- R9: When `mask_en`=0, every active element is written, whatever the value of `mask`.
- R10: Mask bits whose index is at or beyond the number of elements in the active length have no effect on the result.
- R11: After reset, `out_valid` and `result` are 0. The cycle after `in_valid`=1, `out_valid`=1 and `result` holds the value computed from that cycle's inputs. Without `in_valid`, `out_valid`=0 and `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| src_a | input | 512 | Complemented source (three-operand form) |
| src_b | input | 512 | Uncomplemented source; low bits act as the scalar when broadcasting |
| old_dst | input | 512 | Previous destination value |
| mask | input | 16 | Per-element write mask, bit i for element i |
| mask_en | input | 1 | Apply the write mask |
| zero_en | input | 1 | Clear unselected elements instead of merging |
| bcast_en | input | 1 | Broadcast the scalar in the low bits of `src_b` |
| elem64 | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| len_sel | input | 2 | Active vector length select |
| dest_src | input | 1 | Two-operand form: complement `old_dst` |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered result |

## Verification
A wrong lane limit or a wrong mask-index mapping shows up as whole 32-bit or 64-bit slices of `result` that hold old data, zero, or the AND-NOT value when another of those is due. Each such slice appears in the result the cycle after the strobe. Broadcast errors show up as slices that differ from the low scalar pattern. A broken output register shows up as `out_valid` missing, or `result` drifting during idle cycles, which is visible one cycle after the stimulus. The bench compares every strobe against a bit-level model over random lengths, element sizes and masks, plus directed edge cases.

// File: rtl/vandn_pkg.sv
// Package: length encoding and lane-count helper shared by the AND-NOT unit.
// Assumes the active length is 64 bits shifted left by the length select.
package vandn_pkg;
    typedef enum logic [1:0] {LEN_64 = 2'd0, LEN_128 = 2'd1, LEN_256 = 2'd2, LEN_512 = 2'd3} vlen_e;

    localparam int unsigned MIN_VLEN = 64;

    // Number of LW-bit lanes inside the active length.
    function automatic int unsigned active_lanes(input logic [1:0] len, input int unsigned lw);
        return (MIN_VLEN << len) / lw;
    endfunction
endpackage

// File: rtl/vandn_opsel.sv
// Operand selection: picks the complemented operand (first source or old
// destination) and forms the second operand, optionally broadcast.
// Assumes VW is a multiple of 2*LW.
module vandn_opsel #(
    parameter int VW = 512,
    parameter int LW = 32
) (
    input  logic [VW-1:0] src_a,
    input  logic [VW-1:0] src_b,
    input  logic [VW-1:0] old_dst,
    input  logic          bcast_en,
    input  logic          elem64,
    input  logic          dest_src,
    output logic [VW-1:0] op_n,
    output logic [VW-1:0] op_p
);
    localparam int NL = VW / LW;

    // Complemented operand: destination itself in the two-operand form.
    always_comb op_n = dest_src ? old_dst : src_a;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] scal;
        // Scalar slice for this lane: low word, or alternating halves of the low double word.
        always_comb scal = elem64 ? src_b[(i % 2) * LW +: LW] : src_b[LW-1:0];
        // Second operand: broadcast only in the three-operand form.
        always_comb op_p[i*LW +: LW] = (bcast_en && !dest_src) ? scal : src_b[i*LW +: LW];
    end
endmodule

// File: rtl/vandn_lane.sv
// One LW-bit lane: AND-NOT, length limit, mask select and merge/zero policy.
// Assumes a 64-bit element spans lanes 2k and 2k+1, both governed by mask bit k.
module vandn_lane #(
    parameter int LW  = 32,
    parameter int MW  = 16,
    parameter int IDX = 0
) (
    input  logic [LW-1:0] op_n,
    input  logic [LW-1:0] op_p,
    input  logic [LW-1:0] old,
    input  logic [1:0]    len_sel,
    input  logic          elem64,
    input  logic [MW-1:0] mask,
    input  logic          mask_en,
    input  logic          zero_en,
    input  logic          dest_src,
    output logic [LW-1:0] lane_out
);
    import vandn_pkg::*;

    localparam int EI32 = IDX;
    localparam int EI64 = IDX / 2;

    logic in_len;
    logic mbit;
    logic sel;
    logic [LW-1:0] andn;

    // Lane lies inside the active vector length.
    always_comb in_len = (IDX < active_lanes(len_sel, LW));
    // Mask bit for the element that contains this lane.
    always_comb mbit = elem64 ? mask[EI64] : mask[EI32];
    // Lane is written: unmasked, two-operand form, or mask bit set.
    always_comb sel = dest_src || !mask_en || mbit;
    // Core bitwise function.
    always_comb andn = ~op_n & op_p;

    // Final lane value by region and policy.
    always_comb begin
        if (!in_len)      lane_out = dest_src ? old : '0;
        else if (sel)     lane_out = andn;
        else if (zero_en) lane_out = '0;
        else              lane_out = old;
    end

    // R8: a zeroed, unselected active lane reads as zero.
    always_comb begin
        if (in_len && !sel && zero_en)
            a_r8_lane_zero: assert (lane_out == '0);
    end
endmodule

// File: rtl/vandn_unit.sv
// Top: masked vector AND-NOT unit with one-cycle registered result.
// Assumes mask width equals the number of 32-bit lanes in the widest vector.
module vandn_unit #(
    parameter int VW = 512,
    parameter int LW = 32,
    parameter int MW = VW / LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [VW-1:0] src_a,
    input  logic [VW-1:0] src_b,
    input  logic [VW-1:0] old_dst,
    input  logic [MW-1:0] mask,
    input  logic          mask_en,
    input  logic          zero_en,
    input  logic          bcast_en,
    input  logic          elem64,
    input  logic [1:0]    len_sel,
    input  logic          dest_src,
    output logic          out_valid,
    output logic [VW-1:0] result
);
    localparam int NL   = VW / LW;
    localparam int MINV = vandn_pkg::MIN_VLEN;

    logic [VW-1:0] op_n;
    logic [VW-1:0] op_p;
    logic [VW-1:0] next_res;

    vandn_opsel #(.VW(VW), .LW(LW)) u_opsel (
        .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .bcast_en(bcast_en), .elem64(elem64), .dest_src(dest_src),
        .op_n(op_n), .op_p(op_p)
    );

    for (genvar i = 0; i < NL; i++) begin : g_lane
        vandn_lane #(.LW(LW), .MW(MW), .IDX(i)) u_lane (
            .op_n(op_n[i*LW +: LW]), .op_p(op_p[i*LW +: LW]),
            .old(old_dst[i*LW +: LW]), .len_sel(len_sel), .elem64(elem64),
            .mask(mask), .mask_en(mask_en), .zero_en(zero_en),
            .dest_src(dest_src), .lane_out(next_res[i*LW +: LW])
        );
    end

    // Output register: capture on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end

    // R11: strobe produces valid one cycle later.
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11: no strobe, no valid, result held.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    // R4: shortest length in three-operand form clears the upper bits.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dest_src && len_sel == 2'd0) |=> (result[VW-1:MINV] == '0));
    // R2: shortest length in two-operand form passes the upper destination bits.
    a_r2_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dest_src && len_sel == 2'd0) |=> (result[VW-1:MINV] == $past(old_dst[VW-1:MINV])));
    // R8: zeroing with an empty mask in three-operand form gives all zeros.
    a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dest_src && mask_en && zero_en && mask == '0) |=> (result == '0));
endmodule

// File: tb/vandn_unit_test.sv
// Bench: directed corners plus seeded random stimulus against a bit-level model.
module vandn_unit_test;
    localparam int VW = 512;
    localparam int MW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [VW-1:0] src_a = '0, src_b = '0, old_dst = '0;
    logic [MW-1:0] mask = '0;
    logic mask_en = 1'b0, zero_en = 1'b0, bcast_en = 1'b0, elem64 = 1'b0, dest_src = 1'b0;
    logic [1:0] len_sel = 2'd0;
    logic out_valid;
    logic [VW-1:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vandn_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .old_dst(old_dst), .mask(mask), .mask_en(mask_en), .zero_en(zero_en),
        .bcast_en(bcast_en), .elem64(elem64), .len_sel(len_sel), .dest_src(dest_src),
        .out_valid(out_valid), .result(result)
    );

    // Bit-level model built from the requirements, element by element.
    function automatic logic [VW-1:0] model(
        input logic [VW-1:0] a, b, od, input logic [MW-1:0] m,
        input logic men, zen, bc, e64, input logic [1:0] len, input logic two);
        logic [VW-1:0] r = '0;
        int ew = e64 ? 64 : 32;
        int vlen = 64 << len;
        for (int e = 0; e < VW / ew; e++) begin
            for (int k = 0; k < ew; k++) begin
                int p = e * ew + k;
                logic fa = two ? od[p] : a[p];
                logic fb = (bc && !two) ? b[k] : b[p];
                logic wr = two || !men || m[e];
                if (p >= vlen)  r[p] = two ? od[p] : 1'b0;
                else if (wr)    r[p] = ~fa & fb;
                else            r[p] = zen ? 1'b0 : od[p];
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%0b expected=%0b", tag, got, exp);
        end
    endtask

    // Apply one strobe at a falling edge; check at the next falling edge.
    task automatic run(input string tag, input logic [VW-1:0] a, b, od, input logic [MW-1:0] m,
                       input logic men, zen, bc, e64, input logic [1:0] len, input logic two);
        src_a = a; src_b = b; old_dst = od; mask = m; mask_en = men; zero_en = zen;
        bcast_en = bc; elem64 = e64; len_sel = len; dest_src = two; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({tag, " valid"}, out_valid, 1'b1);
        check(tag, result, model(a, b, od, m, men, zen, bc, e64, len, two));
    endtask

    initial begin
        logic [VW-1:0] ones = '1;
        logic [VW-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state.
        check_bit("R11 reset valid", out_valid, 1'b0);
        check("R11 reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3: full length, unmasked, known patterns.
        run("R1 full length", {16{32'hF0F0_00FF}}, {16{32'hFF00_FF0F}}, '0, '0, 0, 0, 0, 0, 2'd3, 0);
        // R3 / R4: each length in three-operand form.
        for (int l = 0; l < 4; l++)
            run("R3 R4 length", rnd_vec(), rnd_vec(), ones, '1, 0, 0, 0, 0, 2'(l), 0);
        // R2: two-operand form ignores src_a, mask, broadcast and zeroing; upper bits pass.
        run("R2 two-operand", ones, rnd_vec(), rnd_vec(), '0, 1, 1, 1, 0, 2'd1, 1);
        // R5 / R7: 32-bit elements, alternating mask, merge.
        run("R5 R7 merge32", rnd_vec(), rnd_vec(), rnd_vec(), 16'h5555, 1, 0, 0, 0, 2'd3, 0);
        // R5 / R8: 64-bit elements, zeroing.
        run("R5 R8 zero64", rnd_vec(), rnd_vec(), rnd_vec(), 16'h00A5, 1, 1, 0, 1, 2'd3, 0);
        // R8: empty mask with zeroing.
        run("R8 empty mask", rnd_vec(), rnd_vec(), rnd_vec(), '0, 1, 1, 0, 0, 2'd3, 0);
        // R6: broadcast of a 32-bit and of a 64-bit scalar.
        run("R6 bcast32", '0, rnd_vec(), '0, '0, 0, 0, 1, 0, 2'd3, 0);
        run("R6 bcast64", '0, rnd_vec(), '0, '0, 0, 0, 1, 1, 2'd2, 0);
        // R9: mask disabled with a zero mask writes everything.
        run("R9 mask off", rnd_vec(), rnd_vec(), ones, '0, 0, 1, 0, 0, 2'd3, 0);
        // R10: 64-bit length, mask bits 2..15 set but ignored.
        run("R10 high mask", rnd_vec(), rnd_vec(), rnd_vec(), 16'hFFFC, 1, 0, 0, 0, 2'd0, 0);
        run("R10 high mask 64", rnd_vec(), rnd_vec(), rnd_vec(), 16'hFF02, 1, 1, 0, 1, 2'd1, 0);

        // R11: idle cycle after input change holds the result and drops valid.
        held = result;
        src_a = rnd_vec(); src_b = rnd_vec(); old_dst = rnd_vec();
        @(negedge clk);
        check_bit("R11 idle valid", out_valid, 1'b0);
        check("R11 idle hold", result, held);

        // Random mix covering R1..R10.
        for (int n = 0; n < 300; n++) begin
            logic r_two = ($urandom % 4) == 0;
            run("R1 R5 R7 random", rnd_vec(), rnd_vec(), rnd_vec(), 16'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), r_two);
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got=timeout expected=completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule